// File: doc/BRIEF.md
# Interrupt Event Status and Enable Register Bank

This block is the event-reporting register bank of a two-wire serial bus controller. The protocol engine sends it one-cycle event pulses: arbitration lost, no acknowledge, access ready, receive ready, transmit ready, receive drain and transmit drain. It also sends a live bus-busy level. The bank keeps each event until software clears it. It offers two read views: a raw view and a view masked by the enable register. It drives one interrupt line, which is the OR of the masked bits.

Software reaches the bank through a simple request/response port that allows 8-bit and 16-bit accesses. Wider accesses are refused with an error response. The same port reaches a small control register that holds the enable, master-select and direction bits, and a soft-reset control. A soft reset clears the bank to its defaults. A reset-done flag is raised only after the enable bit has been set again.

Register map (byte addresses; word index = address bits [3:1]):
- 0x0 raw status. Read only; writes are ignored.
- 0x2 masked status. Reads return raw AND enable; writing 1 clears a bit.
- 0x4 enable set. Reads return the enable register.
- 0x6 enable clear. Reads return the enable register.
- 0x8 control.
- 0xA soft-reset control.
- 0xC reset-done status.
- All other addresses read as 0 and ignore writes.

Top module: `i2c_evt_regbank`

## Requirements
- R1: Each event pulse sets its status bit on the next clock edge, and the bit stays set until software clears it. Event input bit k maps to status bit k: 0 arbitration lost, 1 no acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 receive drain, 6 transmit drain.
- R2: At address 0x2, writing 1 to a status bit clears it and writing 0 leaves it unchanged. Writes to the raw address 0x0 change nothing.
- R3: A read of address 0x2 returns the raw event bits ANDed with the enable register. The irq output is high exactly when at least one masked bit is set.
- R4: Ones written to address 0x4 set enable bits and ones written to address 0x6 clear them. Zeros have no effect. Writing 0xFFFF to 0x6 disables every interrupt. Only bits 6:0 exist, and both addresses read back the enable register.
- R5: Raw status bit 12 shows the bus_busy input as sampled on the cycle of the read. It is never latched, never appears in the masked view and never raises irq.
- R6: Writing 1 to bit 0 of 0xA returns the status, enable and control registers and the reset-done flag to 0. Bit 0 of 0xA then reads 1 while the reset is pending. The pending reset completes, and bit 0 of 0xC (reset-done) reads 1, only on the second clock edge after the control enable bit has been set. Writing the enable bit is therefore visible in a read made two cycles later.
- R7: The control register at 0x8 has enable at bit 15, master select at bit 10 and transmit direction at bit 9. Its other bits read 0. These three bits drive ctl_enable, ctl_master and ctl_transmit.
- R8: req_size 1 is a 16-bit access and req_size 0 is an 8-bit access. An 8-bit access uses the byte lane chosen by address bit 0 (1 selects the high byte). Write data for the lane is taken from req_wdata[7:0], and read data for the lane is returned in rsp_rdata[7:0] with the upper byte 0. A req_size of 2 or 3 changes no register, returns read data 0 and sets rsp_err.
- R9: If an event pulse and a software clear hit the same status bit in the same cycle, the bit stays set.
- R10: Every request is answered on the next clock edge with rsp_valid high for one cycle. Read data and the error flag are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 refused |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Refused access |
| evt_in | input | NUM_EVT | Event pulses from the protocol engine |
| bus_busy | input | 1 | Live bus-busy level |
| ctl_enable | output | 1 | Control enable bit |
| ctl_master | output | 1 | Control master-select bit |
| ctl_transmit | output | 1 | Control direction bit |
| irq | output | 1 | Interrupt request |

## Verification
Every register takes the effect of a request or an event pulse on the clock edge that samples it. The response of a request appears after that same edge. The bench drives each request on a falling edge and samples the response on the next falling edge. A read issued right after a write therefore observes the written value. irq is a function of registered state only, so it is checked one falling edge after the pulse or write that changes it. The reset-done flag is updated on the edge after the one that registers the enable bit. The bench therefore leaves one idle cycle before it reads that flag.

// File: rtl/i2c_evt_regbank.sv
module i2c_evt_regbank #(
  parameter int ADDR_W   = 4,
  parameter int NUM_EVT  = 7,
  parameter int BUSY_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic              bus_busy,
  output logic              ctl_enable,
  output logic              ctl_master,
  output logic              ctl_transmit,
  output logic              irq
);
  localparam int IW = ADDR_W - 1;
  localparam logic [IW-1:0] A_RAW  = IW'(0);
  localparam logic [IW-1:0] A_MSK  = IW'(1);
  localparam logic [IW-1:0] A_ESET = IW'(2);
  localparam logic [IW-1:0] A_ECLR = IW'(3);
  localparam logic [IW-1:0] A_CTRL = IW'(4);
  localparam logic [IW-1:0] A_SYSC = IW'(5);
  localparam logic [IW-1:0] A_SYSS = IW'(6);
  localparam int B_EN = 15, B_MST = 10, B_TRX = 9;

  logic [NUM_EVT-1:0] stat_q, en_q;
  logic [2:0]  ctrl_q;
  logic        pend_q, rdone_q;

  logic [IW-1:0] widx;
  logic          size_ok, wr, rd;
  logic [15:0]   wmask, wdat, wbits;
  logic [15:0]   word, rsel;
  logic          srst_hit;
  logic [NUM_EVT-1:0] clr_bits;

  assign widx    = req_addr[ADDR_W-1:1];
  assign size_ok = (req_size < 2'd2);
  assign wr      = req_valid & req_write & size_ok;
  assign rd      = req_valid & ~req_write & size_ok;
  assign wmask   = (req_size == 2'd1) ? 16'hFFFF : (req_addr[0] ? 16'hFF00 : 16'h00FF);
  assign wdat    = (req_size == 2'd1) ? req_wdata : {2{req_wdata[7:0]}};
  assign wbits   = wdat & wmask;
  assign srst_hit = wr && (widx == A_SYSC) && wbits[0];
  assign clr_bits = (wr && widx == A_MSK) ? wbits[NUM_EVT-1:0] : '0;

  always_comb begin
    word = '0;
    case (widx)
      A_RAW:  begin word[NUM_EVT-1:0] = stat_q; word[BUSY_BIT] = bus_busy; end
      A_MSK:  word[NUM_EVT-1:0] = stat_q & en_q;
      A_ESET, A_ECLR: word[NUM_EVT-1:0] = en_q;
      A_CTRL: begin word[B_EN] = ctrl_q[2]; word[B_MST] = ctrl_q[1]; word[B_TRX] = ctrl_q[0]; end
      A_SYSC: word[0] = pend_q;
      A_SYSS: word[0] = rdone_q;
      default: word = '0;
    endcase
  end

  assign rsel = (req_size == 2'd1) ? word
              : {8'h00, (req_addr[0] ? word[15:8] : word[7:0])};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
      rdone_q <= 1'b0;
    end else if (srst_hit) begin
      stat_q  <= '0;
      en_q    <= '0;
      ctrl_q  <= '0;
      pend_q  <= 1'b1;
      rdone_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | evt_in;
      if (wr && widx == A_ESET) en_q <= en_q | wbits[NUM_EVT-1:0];
      else if (wr && widx == A_ECLR) en_q <= en_q & ~wbits[NUM_EVT-1:0];
      if (wr && widx == A_CTRL) begin
        if (wmask[B_EN])  ctrl_q[2] <= wdat[B_EN];
        if (wmask[B_MST]) ctrl_q[1] <= wdat[B_MST];
        if (wmask[B_TRX]) ctrl_q[0] <= wdat[B_TRX];
      end
      if (ctrl_q[2]) begin
        pend_q  <= 1'b0;
        rdone_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & ~size_ok;
      rsp_rdata <= rd ? rsel : '0;
    end
  end

  assign ctl_enable   = ctrl_q[2];
  assign ctl_master   = ctrl_q[1];
  assign ctl_transmit = ctrl_q[0];
  assign irq          = |(stat_q & en_q);
endmodule

// File: rtl/i2c_evt_regbank_chk.sv
module i2c_evt_regbank_chk #(
  parameter int NUM_EVT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [NUM_EVT-1:0] evt_in,
  input logic [NUM_EVT-1:0] stat,
  input logic [NUM_EVT-1:0] en,
  input logic               ctrl_en,
  input logic               rdone,
  input logic               srst_hit,
  input logic               irq
);
  p_evt_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_in != '0) && !srst_hit) |=> ((stat & $past(evt_in)) == $past(evt_in)));

  p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  p_rdone_after_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdone) |-> $past(ctrl_en));

  p_srst_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> (en == '0 && stat == '0 && !ctrl_en && !rdone));

  p_wide_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size[1]) |=> (rsp_valid && rsp_err));

  p_wide_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size[1]) |=> $stable(en));

  p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

bind i2c_evt_regbank i2c_evt_regbank_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .evt_in(evt_in), .stat(stat_q), .en(en_q), .ctrl_en(ctrl_q[2]),
  .rdone(rdone_q), .srst_hit(srst_hit), .irq(irq)
);

// File: tb/i2c_evt_regbank_tb.sv
module i2c_evt_regbank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd1;
  logic [3:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [6:0]  evt_in = '0;
  logic        bus_busy = 1'b0;
  logic        ctl_enable, ctl_master, ctl_transmit, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] d;
  logic        e;

  i2c_evt_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .evt_in(evt_in), .bus_busy(bus_busy), .ctl_enable(ctl_enable),
    .ctl_master(ctl_master), .ctl_transmit(ctl_transmit), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [3:0] a,
                     input logic [15:0] wd, output logic [15:0] rdat, output logic er);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    chk("R10 rsp_valid", 16'(rsp_valid), 16'd1);
    rdat = rsp_rdata; er = rsp_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] wd);
    logic [15:0] x; logic y;
    acc(1'b1, 2'd1, a, wd, x, y);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] rdat);
    logic y;
    acc(1'b0, 2'd1, a, 16'h0, rdat, y);
  endtask

  task automatic pulse(input logic [6:0] ev);
    evt_in = ev;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    chk("R10 idle rsp", 16'(rsp_valid), 16'd0);
    chk("R3 irq after reset", 16'(irq), 16'd0);
    rd16(4'h0, d); chk("R1 raw reset", d, 16'h0000);
    rd16(4'h4, d); chk("R4 enable reset", d, 16'h0000);
    rd16(4'h8, d); chk("R7 ctrl reset", d, 16'h0000);
    rd16(4'hC, d); chk("R6 rdone at reset", d, 16'h0000);
    @(negedge clk);
    chk("R10 rsp drops", 16'(rsp_valid), 16'd0);
  endtask

  task automatic t_latch;
    pulse(7'h05);
    @(negedge clk);
    rd16(4'h0, d); chk("R1 events sticky", d, 16'h0005);
    rd16(4'h2, d); chk("R3 masked none enabled", d, 16'h0000);
    chk("R3 irq masked off", 16'(irq), 16'd0);
  endtask

  task automatic t_enable;
    wr16(4'h4, 16'h0004);
    rd16(4'h6, d); chk("R4 set one", d, 16'h0004);
    rd16(4'h2, d); chk("R3 masked view", d, 16'h0004);
    chk("R3 irq on", 16'(irq), 16'd1);
    wr16(4'h4, 16'h0041);
    rd16(4'h4, d); chk("R4 set adds", d, 16'h0045);
    wr16(4'h6, 16'h0001);
    rd16(4'h4, d); chk("R4 clear one", d, 16'h0044);
    wr16(4'h6, 16'hFFFF);
    rd16(4'h4, d); chk("R4 clear all", d, 16'h0000);
    chk("R4 irq off", 16'(irq), 16'd0);
  endtask

  task automatic t_w1c;
    wr16(4'h0, 16'hFFFF);
    rd16(4'h0, d); chk("R2 raw write ignored", d, 16'h0005);
    wr16(4'h2, 16'h0001);
    rd16(4'h0, d); chk("R2 w1c one bit", d, 16'h0004);
    wr16(4'h2, 16'h0000);
    rd16(4'h0, d); chk("R2 zero write keeps", d, 16'h0004);
  endtask

  task automatic t_setwins;
    evt_in = 7'h04;
    wr16(4'h2, 16'h0004);
    evt_in = '0;
    rd16(4'h0, d); chk("R9 set beats clear", d, 16'h0004);
    wr16(4'h2, 16'h007F);
    rd16(4'h0, d); chk("R2 clear all", d, 16'h0000);
  endtask

  task automatic t_busy;
    wr16(4'h4, 16'hFFFF);
    rd16(4'h4, d); chk("R4 only bits 6:0", d, 16'h007F);
    bus_busy = 1'b1;
    rd16(4'h0, d); chk("R5 busy live", d, 16'h1000);
    rd16(4'h2, d); chk("R5 busy not masked", d, 16'h0000);
    chk("R5 busy no irq", 16'(irq), 16'd0);
    bus_busy = 1'b0;
    rd16(4'h0, d); chk("R5 busy not latched", d, 16'h0000);
    wr16(4'h6, 16'hFFFF);
  endtask

  task automatic t_bytes;
    acc(1'b1, 2'd0, 4'h4, 16'hAA03, d, e);
    rd16(4'h4, d); chk("R8 byte low write", d, 16'h0003);
    acc(1'b1, 2'd0, 4'h5, 16'h0007, d, e);
    rd16(4'h4, d); chk("R8 high lane no enable bits", d, 16'h0003);
    wr16(4'h6, 16'hFFFF);
    wr16(4'h8, 16'hFFFF);
    rd16(4'h8, d); chk("R7 ctrl fields", d, 16'h8600);
    chk("R7 ctrl pins", {13'd0, ctl_enable, ctl_master, ctl_transmit}, 16'h0007);
    acc(1'b0, 2'd0, 4'h9, 16'h0, d, e); chk("R8 byte read high", d, 16'h0086);
    acc(1'b0, 2'd0, 4'h8, 16'h0, d, e); chk("R8 byte read low", d, 16'h0000);
    acc(1'b1, 2'd0, 4'h9, 16'h0004, d, e);
    rd16(4'h8, d); chk("R8 byte write high", d, 16'h0400);
    chk("R7 master only", {13'd0, ctl_enable, ctl_master, ctl_transmit}, 16'h0002);
  endtask

  task automatic t_wide;
    wr16(4'h4, 16'h0012);
    acc(1'b1, 2'd2, 4'h6, 16'hFFFF, d, e);
    chk("R8 wide write err", 16'(e), 16'd1);
    rd16(4'h4, d); chk("R8 wide write ignored", d, 16'h0012);
    acc(1'b0, 2'd3, 4'h4, 16'h0, d, e);
    chk("R8 wide read err", 16'(e), 16'd1);
    chk("R8 wide read data", d, 16'h0000);
    acc(1'b0, 2'd1, 4'h4, 16'h0, d, e);
    chk("R8 narrow no err", 16'(e), 16'd0);
  endtask

  task automatic t_srst;
    pulse(7'h12);
    wr16(4'hA, 16'h0001);
    rd16(4'hA, d); chk("R6 srst pending", d, 16'h0001);
    rd16(4'hC, d); chk("R6 rdone low", d, 16'h0000);
    rd16(4'h0, d); chk("R6 status default", d, 16'h0000);
    rd16(4'h4, d); chk("R6 enable default", d, 16'h0000);
    rd16(4'h8, d); chk("R6 ctrl default", d, 16'h0000);
    repeat (3) @(negedge clk);
    rd16(4'hC, d); chk("R6 waits for enable", d, 16'h0000);
    wr16(4'h8, 16'h8000);
    @(negedge clk);
    rd16(4'hC, d); chk("R6 rdone set", d, 16'h0001);
    rd16(4'hA, d); chk("R6 srst self-clears", d, 16'h0000);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_enable();
    t_w1c();
    t_setwins();
    t_busy();
    t_bytes();
    t_wide();
    t_srst();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule